// File: doc/BRIEF.md
# Switch Port VLAN Forwarding Filter

This block decides where one received frame may go inside a small Ethernet switch. For each request it takes the ingress port, whether the frame carried a VLAN tag, the tag's VID, and the destination mask that the address lookup produced. It combines them with per-port settings and with its own VLAN table and spanning-tree state. It returns the final egress mask, a drop flag, and the filter ID and VID that the address lookup should use for this frame.

Every port runs in one of three forwarding modes. Matrix mode ignores the VLAN table. Fallback mode and security mode both consult it. On a hit, the allowed set is the entry's member mask ANDed with the ingress port's matrix mask. A port's VLAN attribute decides which VID the frame is classified into. The VLAN table and the spanning-tree state have write ports driven by the switch's control logic. All other settings come in as static configuration vectors.

Top module: `vlan_fwd_filter`

## Requirements
- R1: A request accepted at a clock edge produces its result, with `out_valid` high for one cycle, two rising edges later. `out_valid` is low when no request is in flight.
- R2: Mode encoding: 0 = matrix, 1 = fallback, 2 = security. In matrix mode the destination is `req_dmask` AND the ingress port's matrix mask. The filter ID is 0, and any VLAN table entry for the VID has no effect.
- R3: In fallback or security mode, when the VLAN table hits, the destination is `req_dmask` AND the entry member mask AND the ingress matrix mask. The filter ID is the entry's filter ID.
- R4: In fallback mode, a VLAN table miss forwards using `req_dmask` AND the matrix mask alone, with filter ID 0.
- R5: In security mode, a VLAN table miss sets `out_drop` and gives a zero destination mask.
- R6: `cfg_user` bit = 0 (transparent port): the frame is classified into the port's PVID and any tag VID is ignored. Bit = 1 (user port): a tagged frame uses its own VID and an untagged frame uses the PVID. The chosen VID appears on `out_vid`.
- R7: Table entry layout: member mask at bits 23:16, filter ID at bits 3:1, valid at bit 0. An entry hits only for the exact 12-bit VID it was written with. An entry written with bit 0 clear never hits.
- R8: The destination mask never includes the ingress port.
- R9: Spanning-tree state is 2 bits per (port, filter ID): 0 disabled, 1 blocking/listening, 2 learning, 3 forwarding. After reset every state is 3. For states 0 and 1, the frame's destination is zero and `out_drop` is set. Writing one filter ID's state leaves the port's other filter IDs unchanged.
- R10: When `cfg_untag_drop` is set on a user port whose PVID is 0, an untagged frame is dropped. Tagged frames on that port are still accepted. With the bit clear, all frame types are accepted.
- R11: After reset, `out_valid`, `out_drop` and `out_dmask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr | input | 1 | Write one VLAN table entry |
| tbl_vid | input | 12 | VID of the entry to write |
| tbl_data | input | 32 | Entry contents (layout in R7) |
| stp_wr | input | 1 | Write one spanning-tree state |
| stp_port | input | 3 | Port of the state to write |
| stp_fid | input | 3 | Filter ID of the state to write |
| stp_state | input | 2 | New state value |
| cfg_mode | input | 16 | Two mode bits per port |
| cfg_user | input | 8 | VLAN attribute per port, 1 = user port |
| cfg_pvid | input | 96 | 12-bit PVID per port |
| cfg_matrix | input | 64 | 8-bit matrix mask per port |
| cfg_untag_drop | input | 8 | Untagged-frame reject enable per port |
| req_valid | input | 1 | Request strobe |
| req_port | input | 3 | Ingress port |
| req_tagged | input | 1 | Frame carried a VLAN tag |
| req_vid | input | 12 | VID from the tag |
| req_dmask | input | 8 | Destination mask from address lookup |
| out_valid | output | 1 | Result strobe |
| out_dmask | output | 8 | Final egress mask |
| out_drop | output | 1 | Frame discarded |
| out_fid | output | 3 | Filter ID for address lookup |
| out_vid | output | 12 | Classified VID |

## Verification
The properties assume that the configuration vectors and the ingress port's VLAN attribute do not change while a request is in flight. They also assume that no table write targets the VID being read in the same cycle. The bench changes configuration, table contents and spanning-tree state only while no request is pending, and it waits for each result before issuing the next request. Every request is issued on a falling edge and held for exactly one cycle, so each result is matched to the request that produced it.

// File: rtl/vft_pkg.sv
package vft_pkg;
  localparam int VID_W    = 12;
  localparam int FID_W    = 3;
  localparam int ENT_W    = 32;
  localparam int ENT_VLD  = 0;
  localparam int ENT_FID  = 1;
  localparam int ENT_MEM  = 16;
  localparam int ENT_MEMW = 8;

  typedef enum logic [1:0] {
    MODE_MATRIX   = 2'd0,
    MODE_FALLBACK = 2'd1,
    MODE_SECURE   = 2'd2
  } fwd_mode_e;

  localparam logic [1:0] STP_DISABLED = 2'd0;
  localparam logic [1:0] STP_BLOCKING = 2'd1;
  localparam logic [1:0] STP_LEARNING = 2'd2;
  localparam logic [1:0] STP_FORWARD  = 2'd3;
endpackage

// File: rtl/vft_vlan_table.sv
module vft_vlan_table #(
  parameter int VID_W = 12,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [VID_W-1:0] rd_vid,
  output logic [DW-1:0]    rd_data,
  output logic             rd_hit
);
  localparam int DEPTH = 1 << AW;
  localparam int TW    = VID_W - AW;

  logic [TW+DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] used_q;
  logic [TW+DW-1:0] rd_q;
  logic             used_rd_q;
  logic [TW-1:0]    tag_rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_vid[AW-1:0]] <= {wr_vid[VID_W-1:AW], wr_data};
    if (rd_en) rd_q <= mem[rd_vid[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q    <= '0;
      used_rd_q <= 1'b0;
      tag_rd_q  <= '0;
    end else begin
      if (wr_en) used_q[wr_vid[AW-1:0]] <= 1'b1;
      if (rd_en) begin
        used_rd_q <= used_q[rd_vid[AW-1:0]];
        tag_rd_q  <= rd_vid[VID_W-1:AW];
      end
    end
  end

  assign rd_data = rd_q[DW-1:0];
  assign rd_hit  = used_rd_q && (rd_q[TW+DW-1:DW] == tag_rd_q) && rd_q[0];
endmodule

// File: rtl/vft_stp_store.sv
module vft_stp_store #(
  parameter int N     = 8,
  parameter int FID_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_port,
  input  logic [FID_W-1:0]     wr_fid,
  input  logic [1:0]           wr_state,
  input  logic [$clog2(N)-1:0] rd_port,
  input  logic [FID_W-1:0]     rd_fid,
  output logic [1:0]           rd_state
);
  localparam int NFID = 1 << FID_W;
  localparam int RW   = 2 * NFID;

  logic [RW-1:0] st_q [N];

  generate
    for (genvar p = 0; p < N; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) st_q[p] <= '1;
        else if (wr_en && (wr_port == p[$clog2(N)-1:0]))
          st_q[p][2*wr_fid +: 2] <= wr_state;
      end
    end
  endgenerate

  assign rd_state = st_q[rd_port][2*rd_fid +: 2];
endmodule

// File: rtl/vlan_fwd_filter.sv
module vlan_fwd_filter
  import vft_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 6,
  localparam int PW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_wr,
  input  logic [VID_W-1:0]   tbl_vid,
  input  logic [ENT_W-1:0]   tbl_data,
  input  logic               stp_wr,
  input  logic [PW-1:0]      stp_port,
  input  logic [FID_W-1:0]   stp_fid,
  input  logic [1:0]         stp_state,
  input  logic [2*N-1:0]     cfg_mode,
  input  logic [N-1:0]       cfg_user,
  input  logic [VID_W*N-1:0] cfg_pvid,
  input  logic [N*N-1:0]     cfg_matrix,
  input  logic [N-1:0]       cfg_untag_drop,
  input  logic               req_valid,
  input  logic [PW-1:0]      req_port,
  input  logic               req_tagged,
  input  logic [VID_W-1:0]   req_vid,
  input  logic [N-1:0]       req_dmask,
  output logic               out_valid,
  output logic [N-1:0]       out_dmask,
  output logic               out_drop,
  output logic [FID_W-1:0]   out_fid,
  output logic [VID_W-1:0]   out_vid
);
  // stage 0: VID classification and frame-type check
  logic [VID_W-1:0] in_pvid, cls_vid;
  logic             in_user, in_reject;

  always_comb begin
    in_pvid   = cfg_pvid[req_port*VID_W +: VID_W];
    in_user   = cfg_user[req_port];
    cls_vid   = (in_user && req_tagged) ? req_vid : in_pvid;
    in_reject = cfg_untag_drop[req_port] && in_user && !req_tagged
                && (in_pvid == '0);
  end

  logic             s1_valid, s1_reject;
  logic [PW-1:0]    s1_port;
  logic [VID_W-1:0] s1_vid;
  logic [N-1:0]     s1_dmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_reject <= 1'b0;
      s1_port   <= '0;
      s1_vid    <= '0;
      s1_dmask  <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_reject <= in_reject;
        s1_port   <= req_port;
        s1_vid    <= cls_vid;
        s1_dmask  <= req_dmask;
      end
    end
  end

  logic [ENT_W-1:0] ent;
  logic             ent_hit;

  vft_vlan_table #(.VID_W(VID_W), .AW(AW), .DW(ENT_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_wr),
    .wr_vid  (tbl_vid),
    .wr_data (tbl_data),
    .rd_en   (req_valid),
    .rd_vid  (cls_vid),
    .rd_data (ent),
    .rd_hit  (ent_hit)
  );

  // stage 1: mode resolution, spanning tree, ingress exclusion
  fwd_mode_e        mode;
  logic [N-1:0]     matrix, allowed, self_bit, fin_mask;
  logic [FID_W-1:0] fid;
  logic             miss_drop, blocked, fin_drop;
  logic [1:0]       port_state;

  always_comb begin
    mode      = fwd_mode_e'(cfg_mode[2*s1_port +: 2]);
    matrix    = cfg_matrix[s1_port*N +: N];
    allowed   = matrix;
    fid       = '0;
    miss_drop = 1'b0;
    if (mode != MODE_MATRIX) begin
      if (ent_hit) begin
        allowed = ent[ENT_MEM +: N] & matrix;
        fid     = ent[ENT_FID +: FID_W];
      end else if (mode != MODE_FALLBACK) begin
        allowed   = '0;
        miss_drop = 1'b1;
      end
    end
  end

  vft_stp_store #(.N(N), .FID_W(FID_W)) u_stp (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (stp_wr),
    .wr_port  (stp_port),
    .wr_fid   (stp_fid),
    .wr_state (stp_state),
    .rd_port  (s1_port),
    .rd_fid   (fid),
    .rd_state (port_state)
  );

  always_comb begin
    self_bit           = '0;
    self_bit[s1_port]  = 1'b1;
    blocked            = (port_state == STP_DISABLED) || (port_state == STP_BLOCKING);
    fin_drop           = s1_reject || miss_drop || blocked;
    fin_mask           = fin_drop ? '0 : (s1_dmask & allowed & ~self_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dmask <= '0;
      out_drop  <= 1'b0;
      out_fid   <= '0;
      out_vid   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_dmask <= s1_valid ? fin_mask : '0;
      out_drop  <= s1_valid && fin_drop;
      if (s1_valid) begin
        out_fid <= fid;
        out_vid <= s1_vid;
      end
    end
  end
endmodule

// File: rtl/vlan_fwd_filter_chk.sv
module vlan_fwd_filter_chk #(
  parameter int N     = 8,
  parameter int VID_W = 12,
  parameter int FID_W = 3,
  localparam int PW   = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     cfg_user,
  input logic             req_valid,
  input logic [PW-1:0]    req_port,
  input logic             req_tagged,
  input logic [VID_W-1:0] req_vid,
  input logic [N-1:0]     req_dmask,
  input logic             out_valid,
  input logic [N-1:0]     out_dmask,
  input logic             out_drop,
  input logic [FID_W-1:0] out_fid,
  input logic [VID_W-1:0] out_vid
);
  logic [PW-1:0]    p1, p2;
  logic [N-1:0]     m1, m2;
  logic [VID_W-1:0] v1, v2;
  logic             ut1, ut2;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1 <= '0; p2 <= '0; m1 <= '0; m2 <= '0;
      v1 <= '0; v2 <= '0; ut1 <= 1'b0; ut2 <= 1'b0;
    end else begin
      p1 <= req_port; m1 <= req_dmask; v1 <= req_vid;
      ut1 <= req_valid && req_tagged && cfg_user[req_port];
      p2 <= p1; m2 <= m1; v2 <= v1; ut2 <= ut1;
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ##1 out_valid);

  assert_within_lookup_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_dmask & ~m2) == '0));

  assert_drop_empty_R5: assert property (@(posedge clk) disable iff (rst)
    out_drop |-> (out_dmask == '0));

  assert_tag_vid_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ut2) |-> (out_vid == v2));

  assert_no_hairpin_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dmask[p2] == 1'b0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_drop);
endmodule

bind vlan_fwd_filter vlan_fwd_filter_chk #(.N(N), .VID_W(vft_pkg::VID_W), .FID_W(vft_pkg::FID_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_user   (cfg_user),
  .req_valid  (req_valid),
  .req_port   (req_port),
  .req_tagged (req_tagged),
  .req_vid    (req_vid),
  .req_dmask  (req_dmask),
  .out_valid  (out_valid),
  .out_dmask  (out_dmask),
  .out_drop   (out_drop),
  .out_fid    (out_fid),
  .out_vid    (out_vid)
);

// File: tb/vlan_fwd_filter_test.sv
module vlan_fwd_filter_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_wr = 1'b0;
  logic [11:0] tbl_vid = '0;
  logic [31:0] tbl_data = '0;
  logic        stp_wr = 1'b0;
  logic [2:0]  stp_port = '0;
  logic [2:0]  stp_fid = '0;
  logic [1:0]  stp_state = '0;
  logic [15:0] cfg_mode = '0;
  logic [7:0]  cfg_user = '0;
  logic [95:0] cfg_pvid = '0;
  logic [63:0] cfg_matrix = '1;
  logic [7:0]  cfg_untag_drop = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_port = '0;
  logic        req_tagged = 1'b0;
  logic [11:0] req_vid = '0;
  logic [7:0]  req_dmask = '0;
  logic        out_valid, out_drop;
  logic [7:0]  out_dmask;
  logic [2:0]  out_fid;
  logic [11:0] out_vid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vlan_fwd_filter uut (
    .clk(clk), .rst(rst),
    .tbl_wr(tbl_wr), .tbl_vid(tbl_vid), .tbl_data(tbl_data),
    .stp_wr(stp_wr), .stp_port(stp_port), .stp_fid(stp_fid), .stp_state(stp_state),
    .cfg_mode(cfg_mode), .cfg_user(cfg_user), .cfg_pvid(cfg_pvid),
    .cfg_matrix(cfg_matrix), .cfg_untag_drop(cfg_untag_drop),
    .req_valid(req_valid), .req_port(req_port), .req_tagged(req_tagged),
    .req_vid(req_vid), .req_dmask(req_dmask),
    .out_valid(out_valid), .out_dmask(out_dmask), .out_drop(out_drop),
    .out_fid(out_fid), .out_vid(out_vid)
  );

  function automatic logic [31:0] entry(input logic [7:0] mem, input logic [2:0] fid,
                                        input logic vld);
    return {8'h00, mem, 12'h000, fid, vld};
  endfunction

  task automatic set_port(input int p, input logic [1:0] mode, input logic user,
                          input logic [11:0] pvid, input logic [7:0] mtx, input logic udrop);
    cfg_mode[2*p +: 2]    = mode;
    cfg_user[p]           = user;
    cfg_pvid[12*p +: 12]  = pvid;
    cfg_matrix[8*p +: 8]  = mtx;
    cfg_untag_drop[p]     = udrop;
  endtask

  task automatic write_vlan(input logic [11:0] vid, input logic [31:0] data);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_vid = vid; tbl_data = data;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  task automatic write_stp(input logic [2:0] p, input logic [2:0] fid, input logic [1:0] st);
    @(negedge clk);
    stp_wr = 1'b1; stp_port = p; stp_fid = fid; stp_state = st;
    @(negedge clk);
    stp_wr = 1'b0;
  endtask

  task automatic check(input string req, input logic [24:0] got, input logic [24:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%0b m=%h d=%0b f=%0d vid=%0d expected v=%0b m=%h d=%0b f=%0d vid=%0d",
               req, got[24], got[23:16], got[15], got[14:12], got[11:0],
               exp[24], exp[23:16], exp[15], exp[14:12], exp[11:0]);
    end
  endtask

  task automatic send(input string req, input logic [2:0] p, input logic tg,
                      input logic [11:0] vid, input logic [7:0] dm,
                      input logic [7:0] e_mask, input logic e_drop,
                      input logic [2:0] e_fid, input logic [11:0] e_vid);
    @(negedge clk);
    req_valid = 1'b1; req_port = p; req_tagged = tg; req_vid = vid; req_dmask = dm;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(req, {out_valid, out_dmask, out_drop, out_fid, out_vid},
               {1'b1, e_mask, e_drop, e_fid, e_vid});
  endtask

  task automatic t_reset;
    check("R11 reset", {out_valid, out_dmask, out_drop, 3'd0, 12'd0}, 25'd0);
    @(negedge clk);
    check("R1 idle", {out_valid, 24'd0}, 25'd0);
  endtask

  task automatic t_matrix;
    write_vlan(12'd0, entry(8'h01, 3'd0, 1'b1));
    set_port(2, 2'd0, 1'b0, 12'd0, 8'hB6, 1'b0);
    send("R2 matrix ignores table", 3'd2, 1'b0, 12'd0, 8'hFF, 8'hB2, 1'b0, 3'd0, 12'd0);
  endtask

  task automatic t_hit;
    write_vlan(12'd5, entry(8'h3C, 3'd1, 1'b1));
    set_port(1, 2'd1, 1'b0, 12'd5, 8'h0F, 1'b0);
    send("R3 fallback hit", 3'd1, 1'b0, 12'd0, 8'hFF, 8'h0C, 1'b0, 3'd1, 12'd5);
    set_port(3, 2'd2, 1'b1, 12'd5, 8'hFF, 1'b0);
    send("R3 security hit", 3'd3, 1'b1, 12'd5, 8'hFF, 8'h34, 1'b0, 3'd1, 12'd5);
  endtask

  task automatic t_miss;
    set_port(1, 2'd1, 1'b0, 12'd9, 8'h0F, 1'b0);
    send("R4 fallback miss", 3'd1, 1'b0, 12'd0, 8'hF3, 8'h01, 1'b0, 3'd0, 12'd9);
    send("R5 security miss", 3'd3, 1'b1, 12'd9, 8'hFF, 8'h00, 1'b1, 3'd0, 12'd9);
  endtask

  task automatic t_classify;
    set_port(1, 2'd1, 1'b0, 12'd5, 8'h0F, 1'b0);
    send("R6 transparent ignores tag", 3'd1, 1'b1, 12'd9, 8'hFF, 8'h0C, 1'b0, 3'd1, 12'd5);
    send("R6 user untagged uses PVID", 3'd3, 1'b0, 12'd9, 8'hFF, 8'h34, 1'b0, 3'd1, 12'd5);
  endtask

  task automatic t_entry;
    send("R7 alias VID misses", 3'd3, 1'b1, 12'd69, 8'hFF, 8'h00, 1'b1, 3'd0, 12'd69);
    write_vlan(12'd7, entry(8'hFF, 3'd2, 1'b0));
    set_port(1, 2'd1, 1'b0, 12'd7, 8'h0F, 1'b0);
    send("R7 invalid entry misses", 3'd1, 1'b0, 12'd0, 8'hFF, 8'h0D, 1'b0, 3'd0, 12'd7);
  endtask

  task automatic t_self;
    set_port(0, 2'd0, 1'b0, 12'd0, 8'hFF, 1'b0);
    send("R8 ingress excluded", 3'd0, 1'b0, 12'd0, 8'h01, 8'h00, 1'b0, 3'd0, 12'd0);
  endtask

  task automatic t_stp;
    write_stp(3'd3, 3'd1, 2'd1);
    send("R9 blocking on fid1", 3'd3, 1'b1, 12'd5, 8'hFF, 8'h00, 1'b1, 3'd1, 12'd5);
    set_port(3, 2'd0, 1'b1, 12'd5, 8'hFF, 1'b0);
    send("R9 fid0 untouched", 3'd3, 1'b0, 12'd0, 8'hFF, 8'hF7, 1'b0, 3'd0, 12'd5);
    write_stp(3'd3, 3'd0, 2'd0);
    send("R9 disabled on fid0", 3'd3, 1'b0, 12'd0, 8'hFF, 8'h00, 1'b1, 3'd0, 12'd5);
    set_port(3, 2'd2, 1'b1, 12'd5, 8'hFF, 1'b0);
    write_stp(3'd3, 3'd1, 2'd2);
    send("R9 learning passes", 3'd3, 1'b1, 12'd5, 8'hFF, 8'h34, 1'b0, 3'd1, 12'd5);
  endtask

  task automatic t_accept;
    set_port(4, 2'd1, 1'b1, 12'd0, 8'hFF, 1'b1);
    send("R10 untagged rejected", 3'd4, 1'b0, 12'd0, 8'hFF, 8'h00, 1'b1, 3'd0, 12'd0);
    send("R10 tagged accepted", 3'd4, 1'b1, 12'd5, 8'hFF, 8'h2C, 1'b0, 3'd1, 12'd5);
    set_port(4, 2'd1, 1'b1, 12'd5, 8'hFF, 1'b1);
    send("R10 PVID set accepts", 3'd4, 1'b0, 12'd0, 8'hFF, 8'h2C, 1'b0, 3'd1, 12'd5);
    set_port(4, 2'd1, 1'b1, 12'd0, 8'hFF, 1'b0);
    send("R10 control clear accepts", 3'd4, 1'b0, 12'd0, 8'hFF, 8'h01, 1'b0, 3'd0, 12'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_matrix();
    t_hit();
    t_miss();
    t_classify();
    t_entry();
    t_self();
    t_stp();
    t_accept();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule